// File: doc/BRIEF.md
# VLIW Bundle Issue Controller

This block sits between instruction fetch and five functional units. Each cycle it may take one long instruction word made of five fixed operation slots and send every occupied slot to the unit that owns it. Slot 0 drives the integer/branch unit, slots 1 and 2 drive the two floating-point units, and slots 3 and 4 drive the two memory units. The compiler is trusted to keep the operations of a bundle independent, so the block does no hazard checking between slots in its normal mode.

All units advance together. A stall flag raised by any unit holds the whole bundle, and the bundle goes out in the first cycle in which every flag is low. In compatibility mode the block treats the lowest occupied slot as the leading operation. It checks whether that operation may issue in the same cycle as the other occupied slots. If it may not, the bundle is split: the leading operation issues alone, and the remaining slots issue one issuing cycle later. Fetch must hold the bundle steady until accept is seen.

The controller is a two-state machine. In `WHOLE` it issues complete bundles. The transition WHOLE to TAIL is taken when a split's first half issues. In `TAIL` it waits to issue the remainder. The transition TAIL to WHOLE is taken when that remainder issues. Every other case, including stalls and an absent bundle, keeps the current state.

Top module: `vliw_issue_ctrl`

## Requirements
- R1: Slot k (0 to 4) has its own issue strobe `issue_o[k]`, and its operation is presented on bits `[k*OP_W +: OP_W]` of `issue_op_o`. Slot 0 is integer/branch, slots 1 and 2 are floating-point, and slots 3 and 4 are memory.
- R2: A slot whose `slot_valid_i` bit is 0 is empty. It raises no strobe and its `issue_op_o` slice reads all zeros, whatever its operation field holds.
- R3: A valid bundle with every slot empty is accepted in a single cycle and raises no strobe.
- R4: While any bit of `unit_stall_i` is 1, no strobe and no accept are raised. A held bundle issues in the first cycle in which all stall bits are 0.
- R5: With `compat_mode_i` low, a valid bundle that is not stalled issues all of its occupied slots in one cycle with accept high, even when its slots would conflict.
- R6: An operation field is {opcode[22:15], dst[14:10], srcA[9:5], srcB[4:0]}. In compatibility mode the bundle conflicts when some other occupied slot has the same unit class as the lowest occupied slot, or reads (srcA or srcB) a nonzero dst of that slot. Register 0 is never a dependence.
- R7: A conflicting bundle in compatibility mode first issues only its lowest occupied slot with accept low. In the next issuing cycle it issues all its other occupied slots with accept high.
- R8: A non-conflicting bundle in compatibility mode issues all its occupied slots in one cycle with accept high.
- R9: A stall while the second half of a split is pending holds that second half, and the already issued slot is not reissued.
- R10: During reset, strobes and accept are low. After reset the controller is in `WHOLE`, and the first valid bundle issues whole.
- R11: Accept is high only in a cycle where a complete bundle or the second half of a split issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| compat_mode_i | input | 1 | Enables pair legality checking and splitting |
| bundle_valid_i | input | 1 | A bundle is present on the slot inputs |
| slot_valid_i | input | 5 | Per-slot occupied flag |
| slot_op_i | input | 5*OP_W | Operation fields, slot k at [k*OP_W +: OP_W] |
| unit_stall_i | input | 5 | Per-unit stall flag, unit k owns slot k |
| issue_o | output | 5 | Per-unit issue strobe |
| issue_op_o | output | 5*OP_W | Issued operation per unit, zero when not issued |
| accept_o | output | 1 | Bundle consumed; fetch may advance |

## Verification
Several properties are checked on every clock cycle. Any raised stall silences all strobes and accept. No strobe appears for an empty slot. The first half of a split issues exactly one slot and moves the machine to `TAIL`. Accept never rises without a bundle present. Other behaviour can only be shown by the directed scenarios with known bundles: which slots make up each half of a split, which register patterns count as dependences, the correct operation fields on each unit, and held bundles resuming after a stall.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;

    localparam int unsigned NSLOT = 5;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_MEM = 2'd2
    } unit_cls_e;

    typedef enum logic {
        ST_WHOLE = 1'b0,
        ST_TAIL  = 1'b1
    } iss_state_e;

    // Fixed slot mix: one integer/branch, two floating-point, two memory.
    function automatic unit_cls_e slot_cls(input int unsigned idx);
        if (idx == 0)     return CLS_INT;
        else if (idx < 3) return CLS_FP;
        else              return CLS_MEM;
    endfunction

endpackage

// File: rtl/vliw_pair_check.sv
module vliw_pair_check
    import vliw_issue_pkg::*;
#(
    parameter  int unsigned OPC_W = 8,
    parameter  int unsigned REG_W = 5,
    localparam int unsigned OP_W  = OPC_W + 3 * REG_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NSLOT-1:0]      slot_valid_i,
    input  logic [NSLOT*OP_W-1:0] slot_op_i,
    output logic [NSLOT-1:0]      head_mask_o,
    output logic [NSLOT-1:0]      tail_mask_o,
    output logic                  hazard_o
);

    logic [REG_W-1:0] dst_a  [NSLOT];
    logic [REG_W-1:0] srca_a [NSLOT];
    logic [REG_W-1:0] srcb_a [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_fields
        assign srcb_a[k] = slot_op_i[k*OP_W +: REG_W];
        assign srca_a[k] = slot_op_i[k*OP_W + REG_W +: REG_W];
        assign dst_a[k]  = slot_op_i[k*OP_W + 2*REG_W +: REG_W];
    end

    logic             found;
    int unsigned      head_idx;
    logic [REG_W-1:0] head_dst;

    always_comb begin
        head_mask_o = '0;
        found       = 1'b0;
        head_idx    = 0;
        head_dst    = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_valid_i[i] && !found) begin
                found          = 1'b1;
                head_mask_o[i] = 1'b1;
                head_idx       = i;
                head_dst       = dst_a[i];
            end
        end
        hazard_o = 1'b0;
        for (int j = 0; j < NSLOT; j++) begin
            if (slot_valid_i[j] && !head_mask_o[j]) begin
                if (slot_cls(j) == slot_cls(head_idx)) begin
                    hazard_o = 1'b1;
                end
                if ((head_dst != '0) &&
                    ((srca_a[j] == head_dst) || (srcb_a[j] == head_dst))) begin
                    hazard_o = 1'b1;
                end
            end
        end
        tail_mask_o = slot_valid_i & ~head_mask_o;
    end

    // R6
    hazard_needs_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hazard_o |-> ($countones(slot_valid_i) >= 2));

endmodule

// File: rtl/vliw_issue_fsm.sv
module vliw_issue_fsm
    import vliw_issue_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bundle_valid_i,
    input  logic             stall_any_i,
    input  logic             compat_i,
    input  logic             hazard_i,
    input  logic [NSLOT-1:0] valid_mask_i,
    input  logic [NSLOT-1:0] head_mask_i,
    input  logic [NSLOT-1:0] tail_mask_i,
    output logic [NSLOT-1:0] issue_mask_o,
    output logic             accept_o
);

    iss_state_e state_q, state_d;
    logic       go;

    assign go = bundle_valid_i && !stall_any_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_WHOLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WHOLE: if (go && compat_i && hazard_i) state_d = ST_TAIL;
            ST_TAIL:  if (go) state_d = ST_WHOLE;
            default:  state_d = ST_WHOLE;
        endcase
    end

    always_comb begin
        issue_mask_o = '0;
        accept_o     = 1'b0;
        if (rst_ni && go) begin
            unique case (state_q)
                ST_WHOLE: begin
                    if (compat_i && hazard_i) begin
                        issue_mask_o = head_mask_i;
                    end else begin
                        issue_mask_o = valid_mask_i;
                        accept_o     = 1'b1;
                    end
                end
                ST_TAIL: begin
                    issue_mask_o = tail_mask_i;
                    accept_o     = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7
    tail_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WHOLE && issue_mask_o != '0 && !accept_o) |=> (state_q == ST_TAIL));

    // R7
    split_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_mask_o != '0 && !accept_o) |-> ($countones(issue_mask_o) == 1));

    // R11
    accept_has_bundle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> bundle_valid_i);

endmodule

// File: rtl/vliw_slot_gate.sv
module vliw_slot_gate #(
    parameter int unsigned OP_W = 23
) (
    input  logic            issue_en_i,
    input  logic [OP_W-1:0] op_i,
    output logic            issue_o,
    output logic [OP_W-1:0] op_o
);

    always_comb begin
        issue_o = issue_en_i;
        op_o    = issue_en_i ? op_i : '0;
    end

endmodule

// File: rtl/vliw_issue_ctrl.sv
module vliw_issue_ctrl
    import vliw_issue_pkg::*;
#(
    parameter  int unsigned OPC_W = 8,
    parameter  int unsigned REG_W = 5,
    localparam int unsigned OP_W  = OPC_W + 3 * REG_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  compat_mode_i,
    input  logic                  bundle_valid_i,
    input  logic [NSLOT-1:0]      slot_valid_i,
    input  logic [NSLOT*OP_W-1:0] slot_op_i,
    input  logic [NSLOT-1:0]      unit_stall_i,
    output logic [NSLOT-1:0]      issue_o,
    output logic [NSLOT*OP_W-1:0] issue_op_o,
    output logic                  accept_o
);

    logic [NSLOT-1:0] head_mask, tail_mask, issue_mask;
    logic             hazard;

    vliw_pair_check #(
        .OPC_W (OPC_W),
        .REG_W (REG_W)
    ) pair_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_valid_i (slot_valid_i),
        .slot_op_i    (slot_op_i),
        .head_mask_o  (head_mask),
        .tail_mask_o  (tail_mask),
        .hazard_o     (hazard)
    );

    vliw_issue_fsm fsm_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .bundle_valid_i (bundle_valid_i),
        .stall_any_i    (|unit_stall_i),
        .compat_i       (compat_mode_i),
        .hazard_i       (hazard),
        .valid_mask_i   (slot_valid_i),
        .head_mask_i    (head_mask),
        .tail_mask_i    (tail_mask),
        .issue_mask_o   (issue_mask),
        .accept_o       (accept_o)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        vliw_slot_gate #(.OP_W(OP_W)) gate_i (
            .issue_en_i (issue_mask[k]),
            .op_i       (slot_op_i[k*OP_W +: OP_W]),
            .issue_o    (issue_o[k]),
            .op_o       (issue_op_o[k*OP_W +: OP_W])
        );
    end

    // R4
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|unit_stall_i) |-> (issue_o == '0 && !accept_o));

    // R2
    empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_o & ~slot_valid_i) == '0);

    // R5
    native_whole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!compat_mode_i && (issue_o != '0)) |-> (issue_o == slot_valid_i));

endmodule

// File: tb/vliw_issue_ctrl_tb_top.sv
module vliw_issue_ctrl_tb_top;

    localparam int unsigned NS   = 5;
    localparam int unsigned OPW  = 23;

    logic            clk = 1'b0;
    logic            rst_ni;
    logic            compat;
    logic            bvalid;
    logic [NS-1:0]   svalid;
    logic [OPW-1:0]  ops [NS];
    logic [NS*OPW-1:0] slot_op;
    logic [NS-1:0]   stall;
    logic [NS-1:0]   issue;
    logic [NS*OPW-1:0] issue_op;
    logic            accept;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NS; k++) slot_op[k*OPW +: OPW] = ops[k];
    end

    vliw_issue_ctrl dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .compat_mode_i  (compat),
        .bundle_valid_i (bvalid),
        .slot_valid_i   (svalid),
        .slot_op_i      (slot_op),
        .unit_stall_i   (stall),
        .issue_o        (issue),
        .issue_op_o     (issue_op),
        .accept_o       (accept)
    );

    function automatic logic [OPW-1:0] mk(input int opc, input int dst, input int sa, input int sb);
        return {8'(opc), 5'(dst), 5'(sa), 5'(sb)};
    endfunction

    task automatic chk(input string tag, input logic [NS-1:0] exp_iss, input logic exp_acc);
        n_run++;
        if (issue !== exp_iss || accept !== exp_acc) begin
            n_fail++;
            $display("FAIL %s: issue=%b accept=%b expected issue=%b accept=%b",
                     tag, issue, accept, exp_iss, exp_acc);
        end
        for (int k = 0; k < NS; k++) begin
            logic [OPW-1:0] e;
            e = exp_iss[k] ? ops[k] : '0;
            n_run++;
            if (issue_op[k*OPW +: OPW] !== e) begin
                n_fail++;
                $display("FAIL %s: slot%0d op=%h expected %h", tag, k, issue_op[k*OPW +: OPW], e);
            end
        end
    endtask

    // Inputs are set at a falling edge; check a moment later, then move on.
    task automatic step(input string tag, input logic [NS-1:0] exp_iss, input logic exp_acc);
        #1;
        chk(tag, exp_iss, exp_acc);
        @(negedge clk);
    endtask

    task automatic load(input logic [NS-1:0] v);
        bvalid = 1'b1;
        svalid = v;
    endtask

    task automatic t_reset;
        rst_ni = 1'b0; compat = 1'b0; stall = '0;
        for (int k = 0; k < NS; k++) ops[k] = mk(k + 1, k + 1, 0, 0);
        load(5'b11111);
        @(negedge clk); @(negedge clk);
        step("R10 in reset", 5'b00000, 1'b0);
        rst_ni = 1'b1;
        step("R10 first bundle whole", 5'b11111, 1'b1);
    endtask

    task automatic t_full_map;
        for (int k = 0; k < NS; k++) ops[k] = mk(8'h40 + k, k + 2, k + 9, k + 17);
        load(5'b11111);
        step("R1 all slots", 5'b11111, 1'b1);
    endtask

    task automatic t_empty_slots;
        for (int k = 0; k < NS; k++) ops[k] = mk(8'h70 + k, 7, 8, 9);
        load(5'b10101);
        step("R2 sparse bundle", 5'b10101, 1'b1);
        load(5'b01010);
        step("R2 other sparse bundle", 5'b01010, 1'b1);
    endtask

    task automatic t_all_empty;
        for (int k = 0; k < NS; k++) ops[k] = '0;
        load(5'b00000);
        step("R3 empty bundle", 5'b00000, 1'b1);
        bvalid = 1'b0;
        step("R11 no bundle", 5'b00000, 1'b0);
    endtask

    task automatic t_stall;
        for (int k = 0; k < NS; k++) ops[k] = mk(8'h11, 0, 0, 0);
        load(5'b00111);
        stall = 5'b01000;
        step("R4 stall on idle unit", 5'b00000, 1'b0);
        stall = 5'b00001;
        step("R4 stall on used unit", 5'b00000, 1'b0);
        stall = '0;
        step("R4 release", 5'b00111, 1'b1);
    endtask

    task automatic t_native_conflict;
        compat = 1'b0;
        ops[0] = mk(1, 3, 0, 0); ops[1] = mk(2, 4, 0, 0); ops[2] = mk(3, 5, 4, 3);
        load(5'b00111);
        step("R5 conflict ignored", 5'b00111, 1'b1);
    endtask

    task automatic t_compat_class;
        compat = 1'b1;
        ops[1] = mk(2, 6, 0, 0); ops[2] = mk(3, 7, 1, 2);
        load(5'b00110);
        step("R7 class split head", 5'b00010, 1'b0);
        step("R7 class split tail", 5'b00100, 1'b1);
    endtask

    task automatic t_compat_raw;
        compat = 1'b1;
        ops[0] = mk(1, 3, 0, 0); ops[3] = mk(4, 9, 2, 3);
        load(5'b01001);
        step("R6 dependence split head", 5'b00001, 1'b0);
        step("R6 dependence split tail", 5'b01000, 1'b1);
    endtask

    task automatic t_compat_legal;
        compat = 1'b1;
        ops[0] = mk(1, 3, 0, 0); ops[3] = mk(4, 9, 4, 5);
        load(5'b01001);
        step("R8 independent pair", 5'b01001, 1'b1);
        ops[0] = mk(1, 0, 0, 0); ops[3] = mk(4, 9, 0, 0);
        step("R6 register zero no dependence", 5'b01001, 1'b1);
        ops[0] = mk(1, 3, 0, 0); ops[1] = mk(2, 4, 0, 0); ops[2] = mk(3, 5, 4, 6);
        load(5'b00111);
        step("R8 only head compared", 5'b00111, 1'b1);
    endtask

    task automatic t_tail_stall;
        compat = 1'b1;
        ops[3] = mk(5, 2, 0, 0); ops[4] = mk(6, 1, 2, 0);
        load(5'b11000);
        step("R9 split head", 5'b01000, 1'b0);
        stall = 5'b00010;
        step("R9 tail held", 5'b00000, 1'b0);
        step("R9 tail still held", 5'b00000, 1'b0);
        stall = '0;
        step("R9 tail released", 5'b10000, 1'b1);
        bvalid = 1'b0;
        step("R9 back to whole", 5'b00000, 1'b0);
        compat = 1'b0;
    endtask

    initial begin
        bvalid = 1'b0; svalid = '0; rst_ni = 1'b0; compat = 1'b0; stall = '0;
        for (int k = 0; k < NS; k++) ops[k] = '0;
        @(negedge clk);
        t_reset();
        t_full_map();
        t_empty_slots();
        t_all_empty();
        t_stall();
        t_native_conflict();
        t_compat_class();
        t_compat_raw();
        t_compat_legal();
        t_tail_stall();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all): finished=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule